// File: doc/BRIEF.md
# Flash Block Write-Protection Checker

This block sits in front of the program and erase engine of a boot-block flash array. For every program or erase command it decides whether the target block may be written. The decision combines four inputs: a VPP-above-lockout flag from the analog comparator, the write-protect pin, the reset pin, and a lock map. The lock map follows the boot configuration (top or bottom) and the array density (8 or 16 Mbit).

A refused command leaves a sticky record in a status byte. That record tells the controller whether the refusal came from low programming voltage, from a locked or nonexistent block, and whether the command was a program or an erase. The record stays until a clear-status strobe arrives or the reset pin goes low.

The array has a parameter region of eight small blocks at the boot end, and main blocks fill the rest. The two parameter blocks at the outer edge and every main block can be locked by write-protect. The six inner parameter blocks can always be written.

Top module: `flash_wp_guard`

## Requirements
- R1: While `pin_rst_ni` is low, every command is refused (`grant_o` stays 0) and the status byte reads 0, whatever the other inputs are.
- R2: With the reset pin high and `vpp_ok_i` low, every command is refused and status bit 3 is set.
- R3: With VPP ok, the reset pin high and `wp_ni` low, a command to a lockable block is refused and sets status bit 1. The last block is 38 for 16 Mbit (`dens_large_i`=1) and 22 for 8 Mbit. For top boot (`top_boot_i`=1), blocks 0 up to last−8 and the two highest blocks are lockable. For bottom boot, blocks 0, 1 and 8 up to the last block are lockable.
- R4: Under the R3 conditions, a command to any other in-range block is granted and sets no status bit.
- R5: With VPP ok and both `wp_ni` and the reset pin high, a command to any in-range block is granted.
- R6: Every refusal while the reset pin is high also sets status bit 4 for a program command (`cmd_erase_i`=0) or status bit 5 for an erase command.
- R7: With VPP low and a target block that is also locked, both status bit 3 and status bit 1 are set.
- R8: A block number above the last block for the selected density is refused and sets status bit 1, whatever the state of `wp_ni`.
- R9: Status bits stay set until a `clr_sts_i` strobe or a low reset pin. A refusal in the same cycle as a clear strobe leaves only the new error bits.
- R10: `grant_o` goes high for exactly one cycle, the cycle after a granted `cmd_vld_i` strobe, and is low otherwise. Status bits 0, 2, 6 and 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block's registers |
| vpp_ok_i | input | 1 | Programming voltage at or above lockout |
| wp_ni | input | 1 | Write-protect pin, active low |
| pin_rst_ni | input | 1 | Device reset pin, active low |
| top_boot_i | input | 1 | 1 = parameter blocks at the top, 0 = at the bottom |
| dens_large_i | input | 1 | 1 = 16-Mbit layout (39 blocks), 0 = 8-Mbit (23 blocks) |
| blk_i | input | 6 | Target block number |
| cmd_vld_i | input | 1 | Program/erase command strobe |
| cmd_erase_i | input | 1 | 1 = erase, 0 = program |
| clr_sts_i | input | 1 | Clear-status strobe |
| grant_o | output | 1 | Registered permission pulse for the command |
| sts_o | output | 8 | Sticky status byte (bit 1 lock, 3 VPP, 4 program, 5 erase) |

## Verification
Some properties hold on every cycle, and the assertions check those. They cover:
- the cleared status and absent grant while the reset pin is low;
- refusal with the VPP bit under low voltage;
- the grant for in-range blocks when protection is off;
- the one-cycle grant;
- the sticky retention of error bits;
- the pairing of every refusal cause with a command-type bit, and the reserved zero bits.

The exact lockable set for each of the four layouts needs scenarios. So do the free inner parameter blocks, the out-of-range blocks and a clear that coincides with a new error. The bench covers them by sweeping every block number in every layout and by random commands against a reference model.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;
  localparam int STS_W  = 8;
  localparam int SR_LCK = 1;
  localparam int SR_VPP = 3;
  localparam int SR_PGM = 4;
  localparam int SR_ERS = 5;

  typedef struct packed {
    logic vpp_low;
    logic blk_lock;
  } refuse_t;
endpackage

// File: rtl/flash_wp_lock_map.sv
module flash_wp_lock_map #(
  parameter int BLK_W      = 6,
  parameter int PARAM_BLKS = 8,
  parameter int EDGE_LOCK  = 2,
  parameter int MAIN_SMALL = 15,
  parameter int MAIN_LARGE = 31
) (
  input  logic             top_boot_i,
  input  logic             dens_large_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic             lockable_o,
  output logic             out_of_range_o
);
  localparam int LAST_SMALL = MAIN_SMALL + PARAM_BLKS - 1;
  localparam int LAST_LARGE = MAIN_LARGE + PARAM_BLKS - 1;

  logic [BLK_W-1:0] last_blk;
  logic             in_main, in_edge;

  always_comb begin
    last_blk = dens_large_i ? BLK_W'(LAST_LARGE) : BLK_W'(LAST_SMALL);
    if (top_boot_i) begin
      in_main = blk_i <= (last_blk - BLK_W'(PARAM_BLKS));
      in_edge = blk_i >= (last_blk - BLK_W'(EDGE_LOCK - 1));
    end else begin
      in_main = blk_i >= BLK_W'(PARAM_BLKS);
      in_edge = blk_i <  BLK_W'(EDGE_LOCK);
    end
    out_of_range_o = blk_i > last_blk;
    lockable_o     = in_main | in_edge;
  end
endmodule

// File: rtl/flash_wp_decide.sv
module flash_wp_decide
  import flash_wp_pkg::*;
(
  input  logic             pin_rst_ni,
  input  logic             vpp_ok_i,
  input  logic             wp_ni,
  input  logic             cmd_erase_i,
  input  logic             lockable_i,
  input  logic             out_of_range_i,
  output logic             ok_o,
  output logic [STS_W-1:0] err_o
);
  refuse_t why;

  always_comb begin
    why.vpp_low  = ~vpp_ok_i;
    why.blk_lock = out_of_range_i | (~wp_ni & lockable_i);
    err_o = '0;
    if (pin_rst_ni) begin
      err_o[SR_VPP] = why.vpp_low;
      err_o[SR_LCK] = why.blk_lock;
      if (|why) begin
        if (cmd_erase_i) err_o[SR_ERS] = 1'b1;
        else             err_o[SR_PGM] = 1'b1;
      end
    end
    ok_o = pin_rst_ni & ~(|why);
  end
endmodule

// File: rtl/flash_wp_status.sv
module flash_wp_status
  import flash_wp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_rst_ni,
  input  logic             cmd_vld_i,
  input  logic             clr_sts_i,
  input  logic             ok_i,
  input  logic [STS_W-1:0] err_i,
  output logic             grant_o,
  output logic [STS_W-1:0] sts_o
);
  logic [STS_W-1:0] sts_q;
  logic             grant_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q   <= '0;
      grant_q <= 1'b0;
    end else if (!pin_rst_ni) begin
      sts_q   <= '0;
      grant_q <= 1'b0;
    end else begin
      grant_q <= cmd_vld_i & ok_i;
      // new error wins over a coincident clear
      sts_q   <= (clr_sts_i ? '0 : sts_q) | (cmd_vld_i ? err_i : '0);
    end
  end

  assign grant_o = grant_q;
  assign sts_o   = sts_q;
endmodule

// File: rtl/flash_wp_guard.sv
module flash_wp_guard
  import flash_wp_pkg::*;
#(
  parameter int BLK_W      = 6,
  parameter int PARAM_BLKS = 8,
  parameter int EDGE_LOCK  = 2,
  parameter int MAIN_SMALL = 15,
  parameter int MAIN_LARGE = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vpp_ok_i,
  input  logic             wp_ni,
  input  logic             pin_rst_ni,
  input  logic             top_boot_i,
  input  logic             dens_large_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic             cmd_vld_i,
  input  logic             cmd_erase_i,
  input  logic             clr_sts_i,
  output logic             grant_o,
  output logic [STS_W-1:0] sts_o
);
  logic             lockable, out_of_range, ok;
  logic [STS_W-1:0] err;

  flash_wp_lock_map #(
    .BLK_W(BLK_W), .PARAM_BLKS(PARAM_BLKS), .EDGE_LOCK(EDGE_LOCK),
    .MAIN_SMALL(MAIN_SMALL), .MAIN_LARGE(MAIN_LARGE)
  ) u_map (
    .top_boot_i    (top_boot_i),
    .dens_large_i  (dens_large_i),
    .blk_i         (blk_i),
    .lockable_o    (lockable),
    .out_of_range_o(out_of_range)
  );

  flash_wp_decide u_dec (
    .pin_rst_ni    (pin_rst_ni),
    .vpp_ok_i      (vpp_ok_i),
    .wp_ni         (wp_ni),
    .cmd_erase_i   (cmd_erase_i),
    .lockable_i    (lockable),
    .out_of_range_i(out_of_range),
    .ok_o          (ok),
    .err_o         (err)
  );

  flash_wp_status u_sts (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_rst_ni(pin_rst_ni),
    .cmd_vld_i (cmd_vld_i),
    .clr_sts_i (clr_sts_i),
    .ok_i      (ok),
    .err_i     (err),
    .grant_o   (grant_o),
    .sts_o     (sts_o)
  );
endmodule

// File: rtl/flash_wp_guard_chk.sv
module flash_wp_guard_chk
  import flash_wp_pkg::*;
#(
  parameter int BLK_W      = 6,
  parameter int PARAM_BLKS = 8,
  parameter int MAIN_SMALL = 15,
  parameter int MAIN_LARGE = 31
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             vpp_ok_i,
  input logic             wp_ni,
  input logic             pin_rst_ni,
  input logic             dens_large_i,
  input logic [BLK_W-1:0] blk_i,
  input logic             cmd_vld_i,
  input logic             clr_sts_i,
  input logic             grant_o,
  input logic [STS_W-1:0] sts_o
);
  logic [BLK_W-1:0] last_blk;
  assign last_blk = dens_large_i ? BLK_W'(MAIN_LARGE + PARAM_BLKS - 1)
                                 : BLK_W'(MAIN_SMALL + PARAM_BLKS - 1);

  p_pin_rst_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_rst_ni |=> (!grant_o && sts_o == '0));

  p_vpp_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_i && pin_rst_ni && !vpp_ok_i) |=> (!grant_o && sts_o[SR_VPP]));

  p_unlocked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_i && pin_rst_ni && vpp_ok_i && wp_ni && blk_i <= last_blk) |=> grant_o);

  p_type_bit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_o[SR_VPP] || sts_o[SR_LCK]) |-> (sts_o[SR_PGM] || sts_o[SR_ERS]));

  p_oor_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_i && pin_rst_ni && blk_i > last_blk) |=> (!grant_o && sts_o[SR_LCK]));

  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_rst_ni && !clr_sts_i) |=> ((sts_o & $past(sts_o)) == $past(sts_o)));

  p_grant_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_vld_i |=> !grant_o);

  p_rsvd_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_o[0] == 1'b0 && sts_o[2] == 1'b0 && sts_o[7:6] == 2'b00));
endmodule

bind flash_wp_guard flash_wp_guard_chk #(
  .BLK_W(BLK_W), .PARAM_BLKS(PARAM_BLKS),
  .MAIN_SMALL(MAIN_SMALL), .MAIN_LARGE(MAIN_LARGE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .vpp_ok_i    (vpp_ok_i),
  .wp_ni       (wp_ni),
  .pin_rst_ni  (pin_rst_ni),
  .dens_large_i(dens_large_i),
  .blk_i       (blk_i),
  .cmd_vld_i   (cmd_vld_i),
  .clr_sts_i   (clr_sts_i),
  .grant_o     (grant_o),
  .sts_o       (sts_o)
);

// File: tb/flash_wp_guard_tb.sv
module flash_wp_guard_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       vpp_ok_i = 1'b1, wp_ni = 1'b1, pin_rst_ni = 1'b1;
  logic       top_boot_i = 1'b0, dens_large_i = 1'b1;
  logic [5:0] blk_i = '0;
  logic       cmd_vld_i = 1'b0, cmd_erase_i = 1'b0, clr_sts_i = 1'b0;
  logic       grant_o;
  logic [7:0] sts_o;

  int n_chk = 0, n_err = 0;
  logic [7:0] model = '0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  flash_wp_guard u_dut (.*);

  function automatic int last_of(bit d16);
    return d16 ? 38 : 22;
  endfunction

  function automatic bit lockable(int blk, bit topb, bit d16);
    int last = last_of(d16);
    if (blk > last) return 1'b1;
    if (topb) return (blk <= last - 8) || (blk >= last - 1);
    return (blk <= 1) || (blk >= 8);
  endfunction

  function automatic logic [7:0] new_err(bit vpp, bit wpn, bit prst, bit topb,
                                         bit d16, int blk, bit ers);
    logic [7:0] e = '0;
    if (!prst) return e;
    if (!vpp) e[3] = 1'b1;
    if (blk > last_of(d16) || (!wpn && lockable(blk, topb, d16))) e[1] = 1'b1;
    if (e != 0) e[ers ? 5 : 4] = 1'b1;
    return e;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_cmd(bit vpp, bit wpn, bit prst, bit topb, bit d16,
                        int blk, bit ers, bit clr);
    logic [7:0] e;
    bit ok;
    string req;
    e  = new_err(vpp, wpn, prst, topb, d16, blk, ers);
    ok = prst && (e == 0);
    if (!prst) req = "R1";
    else if (blk > last_of(d16)) req = "R8";
    else if (!vpp && e[1]) req = "R7";
    else if (!vpp) req = "R2";
    else if (!wpn && lockable(blk, topb, d16)) req = "R3";
    else if (!wpn) req = "R4";
    else req = "R5";
    vpp_ok_i = vpp; wp_ni = wpn; pin_rst_ni = prst; top_boot_i = topb;
    dens_large_i = d16; blk_i = 6'(blk); cmd_erase_i = ers; clr_sts_i = clr;
    cmd_vld_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    cmd_vld_i = 1'b0; clr_sts_i = 1'b0;
    model = prst ? ((clr ? 8'h00 : model) | e) : 8'h00;
    chk(req, {7'd0, grant_o}, {7'd0, ok});
    chk(clr ? "R9" : "R6", sts_o, model);
  endtask

  task automatic idle_chk;
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R10", {7'd0, grant_o}, 8'h00);
    if (pin_rst_ni) chk("R9", sts_o, model);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", {7'd0, grant_o}, 8'h00);
    chk("R1", sts_o, 8'h00);

    // sweep every block of each layout with write-protect low
    for (int d = 0; d < 2; d++)
      for (int t = 0; t < 2; t++)
        for (int b = 0; b < 41; b++) begin
          do_cmd(1'b1, 1'b0, 1'b1, t[0], d[0], b, b[0], 1'b1);
        end

    // R7: low VPP with locked block; R2: low VPP with free block
    do_cmd(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 0, 1'b1, 1'b1);
    chk("R7", sts_o, 8'h2A);
    do_cmd(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4, 1'b0, 1'b1);
    chk("R2", sts_o, 8'h18);
    idle_chk();
    idle_chk();
    // R8 with write-protect high
    do_cmd(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 23, 1'b0, 1'b0);
    // R9: sticky across grants, then clear alone
    do_cmd(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 5, 1'b0, 1'b0);
    chk("R9", sts_o, 8'h1A);
    clr_sts_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    clr_sts_i = 1'b0; model = '0;
    chk("R9", sts_o, 8'h00);
    // R1: pin reset clears status and blocks commands
    do_cmd(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 0, 1'b0, 1'b0);
    do_cmd(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 33, 1'b0, 1'b0);
    chk("R1", sts_o, 8'h00);
    pin_rst_ni = 1'b1;

    void'($urandom(32'd1234));
    for (int i = 0; i < 600; i++) begin
      int r = $urandom_range(0, 9);
      do_cmd(r != 0, $urandom_range(0, 1) == 1, $urandom_range(0, 15) != 0,
             $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
             $urandom_range(0, 42), $urandom_range(0, 1) == 1,
             $urandom_range(0, 5) == 0);
      if (r == 9) idle_chk();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule